// File: doc/BRIEF.md
# Triggered Conversion Holdoff Controller

This block decides when a measurement engine may start a conversion. It takes trigger requests from one of three sources: an internal free-running rate generator, an external trigger line and a manual pushbutton. The mode select input picks the source. The two pin sources are active low. Each passes through a synchronizer and a falling-edge detector, so one active edge makes exactly one request. Every request leaves the block as a one-cycle pulse on `trig_out`.

With `hold_en` low, the block uses a request directly as a convert command. With `hold_en` high, an attached sampling front end takes the `trig_out` pulse, finishes its work, and then returns the command on `cmd_ret`.

An accepted command starts a fixed lockout window that cannot be retriggered. During that window every further command is dropped, not queued. The busy output and an active-low lamp drive show the window. Durations are counted in ticks of `TICK_DIV` clock cycles. The defaults give a 1 µs tick at 50 MHz, a 60 ms lockout and a 250 ms auto period.

Top module: `thp_holdoff_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `conv_cmd`, `trig_out` and `busy` are 0 and `busy_lamp_n` is 1.
- R2: `mode_sel` selects the request source: 2'b00 auto, 2'b01 external, 2'b10 manual, 2'b11 none. Edges on a source that is not selected produce no `trig_out` and no `conv_cmd`.
- R3: In auto mode, a request is made every AUTO_TICKS*TICK_DIV cycles. The first one comes AUTO_TICKS*TICK_DIV rising edges after the mode becomes auto. The period counter is held cleared in every other mode.
- R4: In external mode, a falling edge on `ext_trig_n` produces `trig_out` at the third rising clock edge after the change. In direct mode it also produces `conv_cmd` at that edge. A rising edge, or a line held low, produces nothing further.
- R5: In manual mode, each falling edge of `man_btn_n` produces one request, with the same timing as R4.
- R6: An accepted command raises `busy` at the edge where `conv_cmd` is pulsed. `busy` stays high for exactly LOCK_TICKS*TICK_DIV cycles.
- R7: A command that arrives while `busy` is high is dropped and is never issued later. The window cannot be retriggered.
- R8: With `hold_en` high, requests appear only on `trig_out`. A rising edge on `cmd_ret` produces `conv_cmd` at the next clock edge. A `cmd_ret` held high gives one command. With `hold_en` low, `cmd_ret` is ignored.
- R9: `busy_lamp_n` is the inverse of `busy` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_sel | input | 2 | Source select: 00 auto, 01 external, 10 manual, 11 none |
| ext_trig_n | input | 1 | External trigger, active on the falling edge, asynchronous |
| man_btn_n | input | 1 | Manual pushbutton, active low, asynchronous |
| hold_en | input | 1 | 1: commands come back from the front end on cmd_ret |
| cmd_ret | input | 1 | Delayed command return, synchronous, rising edge active |
| trig_out | output | 1 | One-cycle request pulse to the front end |
| conv_cmd | output | 1 | One-cycle convert command to the measurement engine |
| busy | output | 1 | High during the lockout window |
| busy_lamp_n | output | 1 | Active-low busy lamp drive |

## Verification
The bench builds the block with TICK_DIV=4, LOCK_TICKS=10 and AUTO_TICKS=15. This gives a 40-cycle lockout and a 60-cycle auto period. Several whole auto periods, complete lockout windows and rejected edges near a window's end then fit into a few hundred cycles. With the auto period longer than the lockout, every auto request is accepted. Edges placed a few cycles after a command exercise the drop-not-queue rule in both direct and hold modes.

// File: rtl/thp_pkg.sv
package thp_pkg;
  typedef enum logic [1:0] {
    TRG_AUTO = 2'b00,
    TRG_EXT  = 2'b01,
    TRG_MAN  = 2'b10,
    TRG_OFF  = 2'b11
  } trg_mode_e;
endpackage

// File: rtl/thp_edge_sync.sv
module thp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall_o
);
  // stages 0..STAGES-1 synchronize, stage STAGES holds the previous value
  logic [STAGES:0] sq_q, sq_d;

  always_comb begin
    sq_d[0] = pin_n;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_comb sq_d[g] = sq_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq_q <= '1;
    else        sq_q <= sq_d;
  end

  assign fall_o = sq_q[STAGES] & ~sq_q[STAGES-1];
endmodule

// File: rtl/thp_rate_gen.sv
module thp_rate_gen #(
  parameter int TICK_DIV   = 50,
  parameter int AUTO_TICKS = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic fire_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TCK_W = (AUTO_TICKS > 1) ? $clog2(AUTO_TICKS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [TCK_W-1:0] TCK_LAST = TCK_W'(AUTO_TICKS - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [TCK_W-1:0] tck_q, tck_d;
  logic             tick_end;

  assign tick_end = (pre_q == PRE_LAST);

  always_comb begin
    pre_d = pre_q;
    tck_d = tck_q;
    if (!run_i) begin
      pre_d = '0;
      tck_d = '0;
    end else if (tick_end) begin
      pre_d = '0;
      tck_d = (tck_q == TCK_LAST) ? '0 : tck_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      tck_q <= '0;
    end else begin
      pre_q <= pre_d;
      tck_q <= tck_d;
    end
  end

  assign fire_o = run_i & tick_end & (tck_q == TCK_LAST);
endmodule

// File: rtl/thp_lockout.sv
module thp_lockout #(
  parameter int TICK_DIV   = 50,
  parameter int LOCK_TICKS = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CNT_W = $clog2(LOCK_TICKS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_TICKS);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active;

  assign active = (cnt_q != '0);

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (start_i) begin
      pre_d = '0;
      cnt_d = CNT_LOAD;
    end else if (active) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        cnt_d = cnt_q - 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = active;
endmodule

// File: rtl/thp_holdoff_ctrl.sv
module thp_holdoff_ctrl
  import thp_pkg::*;
#(
  parameter int TICK_DIV    = 50,
  parameter int LOCK_TICKS  = 60000,
  parameter int AUTO_TICKS  = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       ext_trig_n,
  input  logic       man_btn_n,
  input  logic       hold_en,
  input  logic       cmd_ret,
  output logic       trig_out,
  output logic       conv_cmd,
  output logic       busy,
  output logic       busy_lamp_n
);
  trg_mode_e mode;
  logic      ext_fall, man_fall, auto_fire;
  logic      req, cand, accept;
  logic      ret_prev_q, ret_rise;
  logic      trig_q, trig_d, cmd_q, cmd_d;
  logic      lock_busy;

  assign mode = trg_mode_e'(mode_sel);

  thp_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_trig_n), .fall_o(ext_fall)
  );

  thp_edge_sync #(.STAGES(SYNC_STAGES)) u_man_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(man_btn_n), .fall_o(man_fall)
  );

  thp_rate_gen #(.TICK_DIV(TICK_DIV), .AUTO_TICKS(AUTO_TICKS)) u_rate (
    .clk(clk), .rst_n(rst_n), .run_i(mode == TRG_AUTO), .fire_o(auto_fire)
  );

  thp_lockout #(.TICK_DIV(TICK_DIV), .LOCK_TICKS(LOCK_TICKS)) u_lock (
    .clk(clk), .rst_n(rst_n), .start_i(accept), .busy_o(lock_busy)
  );

  // source mux
  always_comb begin
    case (mode)
      TRG_AUTO: req = auto_fire;
      TRG_EXT:  req = ext_fall;
      TRG_MAN:  req = man_fall;
      default:  req = 1'b0;
    endcase
  end

  assign ret_rise = cmd_ret & ~ret_prev_q;
  assign cand     = hold_en ? ret_rise : req;
  assign accept   = cand & ~lock_busy;

  always_comb begin
    trig_d = req;
    cmd_d  = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_prev_q <= 1'b0;
      trig_q     <= 1'b0;
      cmd_q      <= 1'b0;
    end else begin
      ret_prev_q <= cmd_ret;
      trig_q     <= trig_d;
      cmd_q      <= cmd_d;
    end
  end

  assign trig_out    = trig_q;
  assign conv_cmd    = cmd_q;
  assign busy        = lock_busy;
  assign busy_lamp_n = ~lock_busy;
endmodule

// File: rtl/thp_holdoff_chk.sv
module thp_holdoff_chk #(
  parameter int TICK_DIV   = 50,
  parameter int LOCK_TICKS = 60000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       hold_en,
  input logic       cmd_ret,
  input logic       trig_out,
  input logic       conv_cmd,
  input logic       busy
);
  localparam int WIN = LOCK_TICKS * TICK_DIV;

  int win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        win_q <= 0;
    else if (conv_cmd) win_q <= 1;
    else if (busy)     win_q <= win_q + 1;
  end

  AST_CMD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_cmd |-> !$past(busy)); // R7
  AST_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_cmd |-> busy); // R6
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_cmd |=> !conv_cmd); // R7
  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (win_q == WIN)); // R6
  AST_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |=> !trig_out); // R2
  AST_HOLD_NEEDS_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_cmd && $past(hold_en)) |-> $past(cmd_ret)); // R8
  AST_DIRECT_WITH_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_cmd && !$past(hold_en)) |-> trig_out); // R4
endmodule

bind thp_holdoff_ctrl thp_holdoff_chk #(
  .TICK_DIV(TICK_DIV), .LOCK_TICKS(LOCK_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .hold_en(hold_en),
  .cmd_ret(cmd_ret), .trig_out(trig_out), .conv_cmd(conv_cmd), .busy(busy)
);

// File: tb/sim_thp_holdoff_ctrl.sv
`timescale 1ns/1ps
module sim_thp_holdoff_ctrl;
  localparam int DIV  = 4;
  localparam int LOCK = 10;
  localparam int AUTO = 15;
  localparam int LD   = LOCK * DIV;
  localparam int AP   = AUTO * DIV;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       ext_trig_n, man_btn_n, hold_en, cmd_ret;
  logic       trig_out, conv_cmd, busy, busy_lamp_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  int last_acc = -100000;
  int cq[$];
  string ctag[$];
  int tq[$];
  string ttag[$];
  int run = 0;
  bit lamp_bad = 0;

  always #10 clk = ~clk;

  thp_holdoff_ctrl #(.TICK_DIV(DIV), .LOCK_TICKS(LOCK), .AUTO_TICKS(AUTO)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ext_trig_n(ext_trig_n),
    .man_btn_n(man_btn_n), .hold_en(hold_en), .cmd_ret(cmd_ret),
    .trig_out(trig_out), .conv_cmd(conv_cmd), .busy(busy),
    .busy_lamp_n(busy_lamp_n)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // driver side: expected convert command, subject to the lockout model
  task automatic exp_conv(input int c, input string tag);
    if (c > last_acc + LD) begin
      last_acc = c;
      cq.push_back(c);
      ctag.push_back(tag);
    end
  endtask

  task automatic exp_trig(input int c, input string tag);
    tq.push_back(c);
    ttag.push_back(tag);
  endtask

  // pulse a pin low then high; selected: the mode picks this pin
  task automatic press(input bit use_ext, input bit selected, input string tag);
    int n;
    @(negedge clk);
    n = cyc;
    if (use_ext) ext_trig_n = 1'b0; else man_btn_n = 1'b0;
    if (selected) begin
      exp_trig(n + 3, tag);
      if (!hold_en) exp_conv(n + 3, tag);
    end
    repeat (6) @(negedge clk);
    if (use_ext) ext_trig_n = 1'b1; else man_btn_n = 1'b1;  // rising edge: no request
    repeat (4) @(negedge clk);
  endtask

  task automatic ret_pulse(input int len, input bit counted, input string tag);
    @(negedge clk);
    cmd_ret = 1'b1;
    if (counted) exp_conv(cyc + 1, tag);
    repeat (len) @(negedge clk);
    cmd_ret = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: compare outputs with the queues
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (cq.size() > 0 && cq[0] < cyc) begin
        chk(0, ctag[0], "conv_cmd missing at cycle", 0, cq[0]);
        void'(cq.pop_front()); void'(ctag.pop_front());
      end
      if (conv_cmd) begin
        if (cq.size() > 0 && cq[0] == cyc) begin
          chk(1, ctag[0], "conv_cmd", 1, 1);
          void'(cq.pop_front()); void'(ctag.pop_front());
        end else chk(0, "R7", "unexpected conv_cmd", 1, 0);
      end
      while (tq.size() > 0 && tq[0] < cyc) begin
        chk(0, ttag[0], "trig_out missing at cycle", 0, tq[0]);
        void'(tq.pop_front()); void'(ttag.pop_front());
      end
      if (trig_out) begin
        if (tq.size() > 0 && tq[0] == cyc) begin
          chk(1, ttag[0], "trig_out", 1, 1);
          void'(tq.pop_front()); void'(ttag.pop_front());
        end else chk(0, "R2", "unexpected trig_out", 1, 0);
      end
      if (busy_lamp_n !== !busy) lamp_bad = 1;
      if (busy) run++;
      else if (run > 0) begin
        chk(run == LD, "R6", "busy length", run, LD);
        chk(!lamp_bad, "R9", "lamp tracks busy", lamp_bad, 0);
        run = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'b11; ext_trig_n = 1'b1; man_btn_n = 1'b1;
    hold_en = 1'b0; cmd_ret = 1'b0;
    repeat (3) @(negedge clk);
    chk(conv_cmd == 0, "R1", "conv_cmd in reset", conv_cmd, 0);
    chk(trig_out == 0, "R1", "trig_out in reset", trig_out, 0);
    chk(busy == 0, "R1", "busy in reset", busy, 0);
    chk(busy_lamp_n == 1, "R1", "lamp in reset", busy_lamp_n, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && conv_cmd == 0, "R1", "idle after reset", busy, 0);

    // external source, direct
    mode_sel = 2'b01;
    repeat (4) @(negedge clk);
    press(1, 1, "R4");
    press(1, 1, "R7");           // inside the window: dropped
    repeat (45) @(negedge clk);
    chk(busy == 0, "R7", "no queued command", busy, 0);
    press(1, 1, "R4");
    press(0, 0, "R2");           // button while external selected
    repeat (40) @(negedge clk);

    // manual source
    mode_sel = 2'b10;
    repeat (3) @(negedge clk);
    press(0, 1, "R5");
    press(1, 0, "R2");           // external while manual selected
    repeat (40) @(negedge clk);
    press(0, 1, "R5");
    repeat (40) @(negedge clk);

    // no source
    mode_sel = 2'b11;
    press(1, 0, "R2");
    press(0, 0, "R2");
    repeat (5) @(negedge clk);

    // auto source
    begin
      int n;
      @(negedge clk);
      n = cyc;
      mode_sel = 2'b00;
      for (int k = 1; k <= 3; k++) begin
        exp_trig(n + k * AP, "R3");
        exp_conv(n + k * AP, "R3");
      end
      repeat (3 * AP + 20) @(negedge clk);
      mode_sel = 2'b11;
    end
    repeat (45) @(negedge clk);

    // hold mode: request only goes out, command comes back on cmd_ret
    hold_en = 1'b1;
    mode_sel = 2'b10;
    repeat (3) @(negedge clk);
    press(0, 1, "R8");
    ret_pulse(1, 1, "R8");
    ret_pulse(1, 1, "R7");       // inside window: dropped
    repeat (45) @(negedge clk);
    ret_pulse(4, 1, "R8");       // held high: one command
    repeat (45) @(negedge clk);
    hold_en = 1'b0;
    mode_sel = 2'b11;
    repeat (3) @(negedge clk);
    ret_pulse(1, 0, "R8");       // ignored in direct mode
    repeat (50) @(negedge clk);

    chk(cq.size() == 0, "R7", "outstanding commands", cq.size(), 0);
    chk(tq.size() == 0, "R2", "outstanding triggers", tq.size(), 0);
    chk(busy_lamp_n == 1, "R9", "lamp idle at end", busy_lamp_n, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule